// File: doc/BRIEF.md
# UART Interrupt Enable and Source Arbitration

This block holds the interrupt enable register of a 16550-style UART and turns five raw interrupt conditions from the UART core into one interrupt line and a prioritized four-bit identification code. The conditions are: received data available, transmit holding register empty, receiver line status, modem status and receiver timeout. Each can be masked on its own. A compatibility bit in the enable register decides where the receiver timeout enable comes from. With the bit clear, the receive-data enable also covers the timeout. With the bit set, a dedicated bit controls it.

The enable register sits at offset 1 of an 8-bit register bus and can be reached only while the divisor latch access input is low. The identification code can be read at offset 2. Reading it, or writing the transmit holding register at offset 0, acknowledges a pending transmit-empty condition. The other four conditions are levels that the UART core holds until their own causes are cleared.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register is read and written at offset 1 only while `dlab` is 0, resets to 00h, and ignores writes made while `dlab` is 1.
- R2: Enable register bits 7 and 6 always read as 0, whatever was written to them.
- R3: While bit 5 (compatibility) is 0, bit 0 enables the receiver timeout interrupt. Bit 4 is stored and reads back as written, but it has no effect on the timeout.
- R4: While bit 5 is 1, bit 4 alone enables the receiver timeout interrupt, and bit 0 no longer affects it.
- R5: Bit 3 enables modem status, bit 2 enables line status, bit 1 enables transmit holding empty and bit 0 enables received data available. A 1 enables the source.
- R6: `irq` is high exactly when at least one pending source is enabled. A change to the enable register shows on `irq` in the cycle after the write.
- R7: `iid` reports the highest-priority enabled pending source, in this order: line status 0110, received data 0100, receiver timeout 1100, transmit empty 0010, modem status 0000. It reads 0001 when no enabled source is pending. Received data ranks above timeout.
- R8: A `thre_set` pulse makes transmit-empty pending. The pending state clears on a write at offset 0 with `dlab` 0, or on a read at offset 2 while transmit-empty is the reported source. A read while another source is reported leaves it pending. A set in the same cycle as a clear wins.
- R9: A read at offset 2 returns {4'b0000, iid}, and a read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlab | input | 1 | Divisor latch access bit; blocks offset 1 while high |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acknowledges transmit-empty) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed offset |
| rda_cond | input | 1 | Received data available level |
| lsr_cond | input | 1 | Receiver line status level |
| msr_cond | input | 1 | Modem status level |
| rto_cond | input | 1 | Receiver timeout level |
| thre_set | input | 1 | Transmit holding register became empty (pulse) |
| irq | output | 1 | Shared interrupt output |
| iid | output | 4 | Prioritized interrupt identification code |

## Verification
The bench writes a series of enable values and, for each one, applies a pattern of pending conditions. All sources pending together with different subsets enabled shows that the priority order picks correctly at each level. Timeout alone, under each of the four combinations of bit 5, bit 4 and bit 0, separates the two timeout enable modes. Received data together with timeout confirms that received data wins that tie. Directed sequences of transmit-empty pulses, writes and identification reads tell an acknowledge of the reported source apart from a read made while a higher-priority source hides it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IEN_W = 6;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_LSR  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_RDA  = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_RTO  = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_THRE = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MSR  = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  typedef struct packed {
    logic lsr;
    logic rda;
    logic rto;
    logic thre;
    logic msr;
  } irq_vec_t;

  localparam int NSRC = $bits(irq_vec_t);
endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int IER_OFS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [IEN_W-1:0]  ien_q,
  output irq_vec_t          eff_en
);
  localparam int BIT_COMP = 5;
  localparam int BIT_RTO  = 4;
  localparam int BIT_MSR  = 3;
  localparam int BIT_LSR  = 2;
  localparam int BIT_THRE = 1;
  localparam int BIT_RDA  = 0;

  logic hit;
  assign hit = reg_wr && !dlab && (reg_addr == ADDR_W'(IER_OFS));

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (hit) ien_q <= reg_wdata[IEN_W-1:0];
  end

  always_comb begin
    eff_en.lsr  = ien_q[BIT_LSR];
    eff_en.rda  = ien_q[BIT_RDA];
    eff_en.thre = ien_q[BIT_THRE];
    eff_en.msr  = ien_q[BIT_MSR];
    eff_en.rto  = ien_q[BIT_COMP] ? ien_q[BIT_RTO] : ien_q[BIT_RDA];
  end
endmodule

// File: rtl/uart_irq_thre_pend.sv
module uart_irq_thre_pend #(
  parameter int ADDR_W  = 3,
  parameter int THR_OFS = 0,
  parameter int IIR_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              thre_set,
  input  logic              thre_reported,
  output logic              pend_q
);
  logic clr;
  assign clr = (reg_wr && !dlab && (reg_addr == ADDR_W'(THR_OFS)))
             || (reg_rd && (reg_addr == ADDR_W'(IIR_OFS)) && thre_reported);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (thre_set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  irq_vec_t          pend,
  input  irq_vec_t          en,
  output logic              irq,
  output logic [CODE_W-1:0] code
);
  irq_vec_t act;
  assign act = pend & en;
  assign irq = |act;

  always_comb begin
    if (act.lsr)       code = CODE_LSR;
    else if (act.rda)  code = CODE_RDA;
    else if (act.rto)  code = CODE_RTO;
    else if (act.thre) code = CODE_THRE;
    else if (act.msr)  code = CODE_MSR;
    else               code = CODE_NONE;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int THR_OFS = 0,
  parameter int IER_OFS = 1,
  parameter int IIR_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rda_cond,
  input  logic              lsr_cond,
  input  logic              msr_cond,
  input  logic              rto_cond,
  input  logic              thre_set,
  output logic              irq,
  output logic [3:0]        iid
);
  logic [IEN_W-1:0]  ien_q;
  irq_vec_t          eff_en;
  irq_vec_t          pend;
  logic              thre_pend;
  logic [CODE_W-1:0] code;

  uart_irq_enreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IER_OFS(IER_OFS)) u_en (
    .clk(clk), .rst(rst), .dlab(dlab), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .ien_q(ien_q), .eff_en(eff_en)
  );

  uart_irq_thre_pend #(.ADDR_W(ADDR_W), .THR_OFS(THR_OFS), .IIR_OFS(IIR_OFS)) u_thre (
    .clk(clk), .rst(rst), .dlab(dlab), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .thre_set(thre_set), .thre_reported(code == CODE_THRE),
    .pend_q(thre_pend)
  );

  always_comb begin
    pend.lsr  = lsr_cond;
    pend.rda  = rda_cond;
    pend.rto  = rto_cond;
    pend.thre = thre_pend;
    pend.msr  = msr_cond;
  end

  uart_irq_arbiter u_arb (.pend(pend), .en(eff_en), .irq(irq), .code(code));

  assign iid = code;

  always_comb begin
    reg_rdata = '0;
    if (!dlab && reg_addr == ADDR_W'(IER_OFS)) reg_rdata[IEN_W-1:0] = ien_q;
    else if (reg_addr == ADDR_W'(IIR_OFS))     reg_rdata[CODE_W-1:0] = code;
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int THR_OFS = 0,
  parameter int IER_OFS = 1,
  parameter int IIR_OFS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dlab,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              lsr_cond,
  input logic              thre_set,
  input logic              irq,
  input logic [3:0]        iid,
  input logic [5:0]        ien_q,
  input logic              thre_pend
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!dlab && reg_addr == ADDR_W'(IER_OFS)) |-> reg_rdata[7:6] == 2'b00); // R2

  AST_DLAB_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && dlab) |=> $stable(ien_q)); // R1

  AST_IRQ_AGREES_IID: assert property (@(posedge clk) disable iff (rst)
    irq == (iid != 4'b0001)); // R6

  AST_LSR_TOP: assert property (@(posedge clk) disable iff (rst)
    (lsr_cond && ien_q[2]) |-> iid == 4'b0110); // R7

  AST_THR_WRITE_ACK: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !dlab && reg_addr == ADDR_W'(THR_OFS) && !thre_set) |=> !thre_pend); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    thre_set |=> thre_pend); // R8

  AST_IIR_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(IIR_OFS)) |-> reg_rdata == {4'b0000, iid}); // R9
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_OFS(THR_OFS), .IER_OFS(IER_OFS), .IIR_OFS(IIR_OFS)
) chk_i (
  .clk(clk), .rst(rst), .dlab(dlab), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .lsr_cond(lsr_cond), .thre_set(thre_set), .irq(irq), .iid(iid),
  .ien_q(ien_q), .thre_pend(thre_pend)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dlab = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rda_cond = 1'b0, lsr_cond = 1'b0, msr_cond = 1'b0, rto_cond = 1'b0;
  logic       thre_set = 1'b0;
  logic       irq;
  logic [3:0] iid;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .dlab(dlab), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rda_cond(rda_cond), .lsr_cond(lsr_cond), .msr_cond(msr_cond),
    .rto_cond(rto_cond), .thre_set(thre_set), .irq(irq), .iid(iid)
  );

  // entry: {ier[7:0], conds {rto,msr,lsr,rda}, thre pulse, exp irq, exp iid[3:0]}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 4'b1111, 1'b1, 1'b0, 4'b0001},  // R5 all masked
    {8'h3F, 4'b1111, 1'b1, 1'b1, 4'b0110},  // R7 line status first
    {8'h0B, 4'b1111, 1'b1, 1'b1, 4'b0100},  // R7 received data next
    {8'h0A, 4'b1111, 1'b1, 1'b1, 4'b0010},  // R7 transmit empty
    {8'h08, 4'b1111, 1'b0, 1'b1, 4'b0000},  // R7 modem status last
    {8'h01, 4'b1000, 1'b0, 1'b1, 4'b1100},  // R3 timeout via bit 0
    {8'h21, 4'b1000, 1'b0, 1'b0, 4'b0001},  // R4 bit 0 ignored for timeout
    {8'h30, 4'b1000, 1'b0, 1'b1, 4'b1100},  // R4 bit 4 enables timeout
    {8'h10, 4'b1000, 1'b0, 1'b0, 4'b0001},  // R3 bit 4 inert
    {8'h04, 4'b0010, 1'b0, 1'b1, 4'b0110},  // R5 line status enable
    {8'h01, 4'b1001, 1'b0, 1'b1, 4'b0100},  // R7 data above timeout
    {8'h02, 4'b0000, 1'b1, 1'b1, 4'b0010},  // R8 pulse sets pending
    {8'h02, 4'b0000, 1'b0, 1'b0, 4'b0001},  // R6 nothing pending
    {8'h3F, 4'b0000, 1'b0, 1'b0, 4'b0001}   // R6 all enabled, none pending
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic dl);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; dlab = dl; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; dlab = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_thre();
    @(negedge clk);
    thre_set = 1'b1;
    @(negedge clk);
    thre_set = 1'b0;
  endtask

  task automatic set_conds(input logic [3:0] c);
    {rto_cond, msr_cond, lsr_cond, rda_cond} = c;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    check("R7 reset iid", {4'd0, iid}, 8'h01);
    rd(3'd1, d); check("R1 reset ier", d, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h55, 1'b0);            // clear transmit-empty pending
      set_conds(4'b0000);
      wr(3'd1, VEC[i][17:10], 1'b0);
      set_conds(VEC[i][9:6]);
      if (VEC[i][5]) pulse_thre();
      @(negedge clk);
      #1;
      check("R6 irq vector", {7'd0, irq}, {7'd0, VEC[i][4]});
      check("R7 iid vector", {4'd0, iid}, {4'd0, VEC[i][3:0]});
    end
    set_conds(4'b0000);

    // R2 reserved bits
    wr(3'd1, 8'hFF, 1'b0);
    rd(3'd1, d); check("R2 reserved read zero", d, 8'h3F);
    // R1 dlab blocks access
    wr(3'd1, 8'h00, 1'b1);
    rd(3'd1, d); check("R1 dlab write ignored", d, 8'h3F);
    @(negedge clk); dlab = 1'b1; reg_addr = 3'd1; #1;
    check("R1 dlab hides register", reg_rdata, 8'h00);
    @(negedge clk); dlab = 1'b0;
    // R3 bit 4 stored when compat 0
    wr(3'd1, 8'h10, 1'b0);
    rd(3'd1, d); check("R3 bit4 readback", d, 8'h10);
    // R6 write reflected next cycle
    rda_cond = 1'b1;
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
    #1 check("R6 irq before write", {7'd0, irq}, 8'h00);
    @(negedge clk); reg_wr = 1'b0;
    #1 check("R6 irq after write", {7'd0, irq}, 8'h01);
    rda_cond = 1'b0;

    // R8 acknowledge by IIR read while reported
    wr(3'd1, 8'h02, 1'b0);
    pulse_thre();
    rd(3'd2, d); check("R9 iir read data", d, 8'h02);
    #1 check("R8 read acknowledges", {4'd0, iid}, 8'h01);
    // R8 read while hidden keeps pending
    wr(3'd1, 8'h06, 1'b0);
    lsr_cond = 1'b1;
    pulse_thre();
    rd(3'd2, d); check("R9 iir read lsr", d, 8'h06);
    lsr_cond = 1'b0;
    #1 check("R8 hidden stays pending", {4'd0, iid}, 8'h02);
    // R8 set wins over clear in the same cycle
    @(negedge clk); reg_addr = 3'd0; reg_wr = 1'b1; thre_set = 1'b1;
    @(negedge clk); reg_wr = 1'b0; thre_set = 1'b0;
    #1 check("R8 set wins", {4'd0, iid}, 8'h02);
    wr(3'd0, 8'hAA, 1'b0);
    #1 check("R8 thr write acknowledges", {4'd0, iid}, 8'h01);
    rd(3'd5, d); check("R9 other offset zero", d, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule